// File: doc/BRIEF.md
# Wake, IO-Timeout and Watchdog Sleep Controller

This block decides whether a small single-wire slave device is asleep or awake. A token receiver in front of it hands over decoded events: a wake pattern, the start of a token, a legal token, an illegal token, a command flag, the last command bit, a busy level from the command engine and a command-done pulse. A wake event seen while asleep brings the device up. On the first awake cycle the block asks for the 0x11 status byte to be queued, which the device sends on the next transmit request.

While awake, two timers can send the device back to sleep. The first is an inactivity timer. Token activity restarts it. It stops counting while a command executes, which runs from the last command bit until the command finishes, and also while the busy level is high. The second is a watchdog. It starts at wake and counts every awake cycle without exception. Nothing clears it except a trip through sleep. A finished command also puts the device to sleep.

Each entry into sleep produces a one-cycle pulse together with a reason code, so that the power logic and any trace logic downstream can tell why the device went down.

Top module: `wake_sleep_ctrl`

## Requirements
- R1: After reset the device is asleep, and awake_o, sleep_o, status_req_o and sleep_why_o are all zero.
- R2: A wake_i seen while asleep makes awake_o high from the next cycle. status_req_o is high for exactly that first awake cycle.
- R3: A wake_i seen while awake has no effect: no timer restarts and no extra status request is made. While asleep, every token and command input is ignored, so awake_o stays low and no sleep_o pulse occurs.
- R4: With no restart event, no execution and no busy level, the device stays awake for exactly TIMEOUT_CYC cycles after the cycle of the last restart event (the wake counts as a restart at cycle 0). It then sleeps with reason 2'b01.
- R5: tok_start_i, tok_legal_i, cmd_flag_i and cmd_last_i each restart the inactivity timer. tok_illegal_i does not restart it. In a cycle where tok_illegal_i is also high, the other events do not restart it either.
- R6: The inactivity timer does not advance in any cycle where cmd_busy_i is high. It also does not advance from the cycle after cmd_last_i until the device sleeps.
- R7: cmd_done_i while awake ends the awake period after that cycle, with reason 2'b11.
- R8: The device sleeps with reason 2'b10 after exactly WDOG_CYC awake cycles, whatever the token, busy or command activity. When this coincides with another cause, the watchdog reason wins. cmd_done_i ranks above the inactivity timer.
- R9: The watchdog count begins from zero on every wake from sleep, so each awake period may last up to the full WDOG_CYC.
- R10: sleep_o is a single-cycle pulse in the first asleep cycle and carries a nonzero sleep_why_o. sleep_why_o is 2'b00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Wake pattern detected |
| tok_start_i | input | 1 | Leading edge of a data token seen |
| tok_legal_i | input | 1 | Legal token completed |
| tok_illegal_i | input | 1 | Illegal token (e.g. overlong low pulse) |
| cmd_flag_i | input | 1 | Legal command flag received |
| cmd_last_i | input | 1 | Last expected command bit received |
| cmd_busy_i | input | 1 | Command engine busy level |
| cmd_done_i | input | 1 | Command finished |
| awake_o | output | 1 | Device awake |
| sleep_o | output | 1 | Pulse on the first cycle of sleep |
| sleep_why_o | output | 2 | Reason for sleep: 01 inactivity, 10 watchdog, 11 command done |
| status_req_o | output | 1 | Queue the 0x11 post-wake status byte |

## Verification
A stuck or mis-loaded inactivity count shows up at the ports as an awake period of the wrong length. The error appears at the very next sleep pulse, because the run length is measured from the last restart event. A watchdog that fails to clear at wake, or that is cleared by token traffic, changes the length of a long, busy awake period by at least one token spacing. A wrong priority or a lost execution flag shows as a wrong reason code, or as an early inactivity sleep in the middle of a command. The monitor compares every sleep pulse against a queued reason and run length, and it treats any pulse it did not expect as a mismatch.

// File: rtl/wake_sleep_ctrl.sv
module wake_sleep_ctrl #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int WDOG_CYC    = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_i,
  input  logic       tok_start_i,
  input  logic       tok_legal_i,
  input  logic       tok_illegal_i,
  input  logic       cmd_flag_i,
  input  logic       cmd_last_i,
  input  logic       cmd_busy_i,
  input  logic       cmd_done_i,
  output logic       awake_o,
  output logic       sleep_o,
  output logic [1:0] sleep_why_o,
  output logic       status_req_o
);

  localparam int IOW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int WDW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam logic [IOW-1:0] IO_LAST = IOW'(TIMEOUT_CYC - 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WDOG_CYC - 1);

  localparam logic [1:0] WHY_IO   = 2'b01;
  localparam logic [1:0] WHY_WDOG = 2'b10;
  localparam logic [1:0] WHY_DONE = 2'b11;

  logic           awake_q, exec_q, sleep_q, stat_q;
  logic [1:0]     why_q;
  logic [IOW-1:0] io_cnt;
  logic [WDW-1:0] wd_cnt;

  logic       restart, io_run, io_hit, wd_hit, done_hit, go_sleep;
  logic [1:0] why_d;

  assign restart  = (tok_start_i | tok_legal_i | cmd_flag_i | cmd_last_i) & ~tok_illegal_i;
  assign io_run   = awake_q & ~exec_q & ~cmd_busy_i;
  assign io_hit   = io_run & ~restart & (io_cnt == IO_LAST);
  assign wd_hit   = awake_q & (wd_cnt == WD_LAST);
  assign done_hit = awake_q & cmd_done_i;
  assign go_sleep = wd_hit | done_hit | io_hit;
  assign why_d    = wd_hit ? WHY_WDOG : (done_hit ? WHY_DONE : WHY_IO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake_q <= 1'b0;
      exec_q  <= 1'b0;
      sleep_q <= 1'b0;
      stat_q  <= 1'b0;
      why_q   <= 2'b00;
      io_cnt  <= '0;
      wd_cnt  <= '0;
    end else begin
      sleep_q <= 1'b0;
      stat_q  <= 1'b0;
      why_q   <= 2'b00;
      if (!awake_q) begin
        if (wake_i) begin
          awake_q <= 1'b1;
          stat_q  <= 1'b1;
          exec_q  <= 1'b0;
          io_cnt  <= '0;
          wd_cnt  <= '0;
        end
      end else if (go_sleep) begin
        awake_q <= 1'b0;
        exec_q  <= 1'b0;
        sleep_q <= 1'b1;
        why_q   <= why_d;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
        if (cmd_last_i)
          exec_q <= 1'b1;
        if (restart)
          io_cnt <= '0;
        else if (io_run)
          io_cnt <= io_cnt + 1'b1;
      end
    end
  end

  assign awake_o      = awake_q;
  assign sleep_o      = sleep_q;
  assign sleep_why_o  = why_q;
  assign status_req_o = stat_q;

endmodule

// File: rtl/wake_sleep_ctrl_chk.sv
module wake_sleep_ctrl_chk #(
  parameter int WDOG_CYC = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_i,
  input logic       cmd_done_i,
  input logic       awake_o,
  input logic       sleep_o,
  input logic [1:0] sleep_why_o,
  input logic       status_req_o
);

  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !awake_o) run_cnt <= 0;
    else                    run_cnt <= run_cnt + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!awake_o && !sleep_o && !status_req_o));

  a_r2_wake_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake_o && wake_i) |=> (awake_o && status_req_o));

  a_r3_status_once: assert property (@(posedge clk) disable iff (!rst_n)
    status_req_o |=> !status_req_o);

  a_r3_asleep_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake_o && !wake_i) |=> !awake_o);

  a_r7_done_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_o && cmd_done_i) |=> (!awake_o && sleep_o && sleep_why_o != 2'b01));

  a_r8_wdog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    awake_o |-> (run_cnt < WDOG_CYC));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |=> !sleep_o);

  a_r10_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(awake_o) |-> sleep_o);

  a_r10_reason_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o == (sleep_why_o != 2'b00)));

endmodule

bind wake_sleep_ctrl wake_sleep_ctrl_chk #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .cmd_done_i(cmd_done_i),
  .awake_o(awake_o), .sleep_o(sleep_o), .sleep_why_o(sleep_why_o),
  .status_req_o(status_req_o)
);

// File: tb/wake_sleep_ctrl_test.sv
`timescale 1ns/1ps
module wake_sleep_ctrl_test;
  localparam int T  = 20;
  localparam int WD = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake_i = 0, tok_start_i = 0, tok_legal_i = 0, tok_illegal_i = 0;
  logic cmd_flag_i = 0, cmd_last_i = 0, cmd_busy_i = 0, cmd_done_i = 0;
  logic awake_o, sleep_o, status_req_o;
  logic [1:0] sleep_why_o;

  always #4 clk = ~clk;

  wake_sleep_ctrl #(.TIMEOUT_CYC(T), .WDOG_CYC(WD)) uut (.*);

  int checks = 0, fails = 0;
  int cyc = 0, run_len = 0, stat_cnt = 0, exp_stat = 0;
  logic [1:0] exp_why[$];
  int         exp_len[$];
  string      exp_tag[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (awake_o) run_len++;
      if (status_req_o) begin
        stat_cnt++;
        check("R2 status on first awake cycle", run_len, 1);
      end
      if (sleep_o) begin
        if (exp_why.size() == 0) begin
          check("R3 unexpected sleep pulse", 1, 0);
        end else begin
          string t = exp_tag.pop_front();
          check({t, " reason"}, int'(sleep_why_o), int'(exp_why.pop_front()));
          check({t, " awake length"}, run_len, exp_len.pop_front());
        end
        run_len = 0;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic wake_dev();
    wake_i = 1;
    @(negedge clk);
    wake_i = 0;
    cyc = 1;
    exp_stat++;
  endtask

  task automatic go(int k);
    while (cyc < k) step();
  endtask

  // sel: 0 start, 1 legal, 2 illegal, 3 flag, 4 last, 5 done, 6 wake
  task automatic pulse(int k, int sel);
    go(k);
    case (sel)
      0: tok_start_i = 1;  1: tok_legal_i = 1;  2: tok_illegal_i = 1;
      3: cmd_flag_i = 1;   4: cmd_last_i = 1;   5: cmd_done_i = 1;
      default: wake_i = 1;
    endcase
    step();
    {tok_start_i, tok_legal_i, tok_illegal_i, cmd_flag_i, cmd_last_i, cmd_done_i, wake_i} = '0;
  endtask

  task automatic expect_sleep(logic [1:0] why, int len, string tag);
    exp_why.push_back(why);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic drain(string tag);
    int n = 0;
    while (exp_why.size() != 0 && n < 400) begin step(); n++; end
    repeat (3) step();
    check({tag, " queue drained"}, exp_why.size(), 0);
    check({tag, " asleep"}, int'(awake_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 awake after reset", int'(awake_o), 0);
    check("R1 sleep after reset", int'(sleep_o), 0);
    check("R1 status after reset", int'(status_req_o), 0);
    check("R1 reason after reset", int'(sleep_why_o), 0);

    // R3: events while asleep are ignored
    pulse(cyc + 2, 1); pulse(cyc + 2, 4); pulse(cyc + 2, 5);
    repeat (3) step();
    check("R3 asleep events ignored", int'(awake_o), 0);

    // R4: idle after wake
    wake_dev();
    check("R2 awake next cycle", int'(awake_o), 1);
    expect_sleep(2'b01, T, "R4 idle timeout");
    drain("R4");

    // R5: legal tokens restart the timer
    wake_dev();
    expect_sleep(2'b01, 45 + T, "R5 legal restarts");
    pulse(15, 1); pulse(30, 1); pulse(45, 1);
    drain("R5a");

    // R5: illegal token does not restart; start does
    wake_dev();
    expect_sleep(2'b01, 3 + T, "R5 illegal no restart");
    pulse(3, 0); pulse(8, 2);
    drain("R5b");

    // R5: illegal in same cycle blocks the restart
    wake_dev();
    expect_sleep(2'b01, T, "R5 illegal dominates");
    go(6); tok_legal_i = 1; tok_illegal_i = 1; step(); tok_legal_i = 0; tok_illegal_i = 0;
    drain("R5c");

    // R3: wake while awake ignored
    wake_dev();
    expect_sleep(2'b01, T, "R3 rewake ignored");
    pulse(12, 6); exp_stat = exp_stat;
    drain("R3");
    check("R3 status pulse count", stat_cnt, exp_stat);

    // R6: busy level freezes the timer
    wake_dev();
    expect_sleep(2'b01, T + 30, "R6 busy freezes");
    go(5); cmd_busy_i = 1; repeat (30) step(); cmd_busy_i = 0;
    drain("R6a");

    // R6/R7: command executes past the timeout, then completes
    wake_dev();
    expect_sleep(2'b11, 60, "R7 done after exec");
    pulse(2, 3); pulse(6, 1); pulse(10, 4); pulse(60, 5);
    drain("R7");

    // R8: watchdog despite traffic; later events ignored while asleep
    wake_dev();
    expect_sleep(2'b10, WD, "R8 watchdog");
    for (int k = 10; k <= 130; k += 10) pulse(k, 1);
    drain("R8a");

    // R9: new wake gives the full watchdog again
    wake_dev();
    expect_sleep(2'b10, WD, "R9 watchdog reload");
    for (int k = 10; k <= 90; k += 10) pulse(k, 1);
    drain("R9");

    // R8: watchdog during execution, done at same cycle loses
    wake_dev();
    expect_sleep(2'b10, WD, "R8 wdog beats done");
    pulse(5, 4); pulse(WD, 5);
    drain("R8b");

    check("R2 total status pulses", stat_cnt, exp_stat);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule